// File: doc/BRIEF.md
# Single-level interrupt controller for an 8-bit CPU core

This block gathers interrupt requests for an 8-bit CPU core and offers the core one vector address at a time. There are six sources:

- two external pins, both active low and idle high;
- two timer overflow pulses;
- a byte-level I2C port flag;
- a bit-level I2C port flag.

There is no priority register, so every source sits on one level. A fixed polling order picks the winner when several requests are pending together. Once the core takes a vector, nothing else is offered until the core signals a return from the handler.

External pin 1 raises a request on both of its edges. Software can therefore time pulse widths, for example from an infrared remote. External pin 0 has two modes, set by a mode input: it either latches a falling edge or follows the pin level. The enable register has no serial-port enable bit, and no serial-port vector exists.

Top module: `irq_ctl_single_level`

## Requirements
- R1: An active-low reset clears the enable register, every pending flag and the in-service flag. During and after reset, `irq_req` is 0, `irq_vec` is 0 and `en_rdata` is 0.
- R2: The enable register has the following bit layout:
  - bit 0: pin 0;
  - bit 1: timer 0;
  - bit 2: pin 1;
  - bit 3: timer 1;
  - bit 5: byte I2C;
  - bit 6: bit I2C;
  - bit 7: global enable;
  - bit 4: always reads 0, and writes to it are ignored.

  A write with `en_wr` high lands on the next rising edge.
- R3: A source requests only when both its own enable bit and the global enable bit are 1. While `irq_req` is 0, `irq_vec` is 0.
- R4: When several sources are active, the winner is chosen in this order, with these vectors: pin 0 (03H), timer 0 (0BH), pin 1 (13H), timer 1 (1BH), byte I2C (2BH), bit I2C (53H).
- R5: Both pins pass through a two-flop synchroniser. A falling or a rising edge on pin 1 sets its pending flag. The flag is visible after the third rising edge that follows the pin change, and not after the second.
- R6: With `it0_edge` = 1, a falling edge on pin 0 latches a flag. That flag stays cleared after service even if the pin is held low. With `it0_edge` = 0, pin 0 requests while its synchronised level is low, two edges after the pin changes.
- R7: Timer pulses, pin 1 edges and pin 0 edges each set a flag. That flag is cleared when the core acknowledges the matching vector. The I2C inputs are levels held by their source, and an acknowledge does not clear them.
- R8: An accepted acknowledge (`irq_ack` together with `irq_req`) takes effect at the next edge. From then on, `irq_req` stays 0 until `reti` is seen, so a new request cannot preempt the one in service.
- R9: `reti` clears the in-service flag at the next edge. Any still-pending request is then offered at once, in polling order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext0_pin | input | 1 | Raw external pin 0, active low |
| ext1_pin | input | 1 | Raw external pin 1, both edges request |
| it0_edge | input | 1 | Pin 0 mode: 1 for falling edge, 0 for low level |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| i2c_byte_req | input | 1 | Byte-level I2C request flag, held by source |
| i2c_bit_req | input | 1 | Bit-level I2C request flag, held by source |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register contents |
| irq_ack | input | 1 | Core takes the offered vector |
| reti | input | 1 | Core returns from the handler |
| irq_req | output | 1 | A vector is being offered |
| irq_vec | output | VEC_W | Offered vector address |

## Verification
A flag that fails to clear on acknowledge shows up as the same vector offered again on the first cycle after `reti`. A lost flag shows up as `irq_req` staying low three edges after a pin change. A stuck in-service flag holds `irq_req` low after `reti`, and the very next request check exposes it. A wrong polling order changes `irq_vec` in the same cycle the competing flags appear, so the table of enable and level patterns catches it without any delay.

// File: rtl/irq_ctl_single_level.sv
module irq_ctl_single_level #(
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext0_pin,
  input  logic             ext1_pin,
  input  logic             it0_edge,
  input  logic             tmr0_ovf,
  input  logic             tmr1_ovf,
  input  logic             i2c_byte_req,
  input  logic             i2c_bit_req,
  input  logic             en_wr,
  input  logic [7:0]       en_wdata,
  output logic [7:0]       en_rdata,
  input  logic             irq_ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);

  localparam int         NSRC    = 6;
  localparam logic [7:0] EN_MASK = 8'hEF;

  function automatic logic [VEC_W-1:0] src_vec(input int idx);
    case (idx)
      0:       return VEC_W'(8'h03);
      1:       return VEC_W'(8'h0B);
      2:       return VEC_W'(8'h13);
      3:       return VEC_W'(8'h1B);
      4:       return VEC_W'(8'h2B);
      default: return VEC_W'(8'h53);
    endcase
  endfunction

  logic [SYNC_STAGES:0] p0_sh, p1_sh;
  logic [7:0]           en_q;
  logic                 ie0_q, ie1_q, tf0_q, tf1_q, svc_q;
  logic [NSRC-1:0]      pend, act, grant;
  logic [VEC_W-1:0]     vec;

  wire p0_now  = p0_sh[SYNC_STAGES-1];
  wire p0_old  = p0_sh[SYNC_STAGES];
  wire p1_now  = p1_sh[SYNC_STAGES-1];
  wire p1_old  = p1_sh[SYNC_STAGES];
  wire p0_fall = p0_old & ~p0_now;
  wire p1_edge = p1_old ^ p1_now;
  wire take    = irq_ack & irq_req;

  assign pend = {i2c_bit_req, i2c_byte_req, tf1_q, ie1_q, tf0_q,
                 it0_edge ? ie0_q : ~p0_now};
  assign act  = pend & {en_q[6], en_q[5], en_q[3:0]} & {NSRC{en_q[7]}};

  always_comb begin
    grant = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  always_comb begin
    vec = '0;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) vec = vec | src_vec(i);
  end

  assign irq_req  = ~svc_q & (|act);
  assign irq_vec  = irq_req ? vec : '0;
  assign en_rdata = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_sh <= '1;
      p1_sh <= '1;
    end else begin
      p0_sh <= {p0_sh[SYNC_STAGES-1:0], ext0_pin};
      p1_sh <= {p1_sh[SYNC_STAGES-1:0], ext1_pin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ie0_q <= 1'b0;
      ie1_q <= 1'b0;
      tf0_q <= 1'b0;
      tf1_q <= 1'b0;
      svc_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_wdata & EN_MASK;

      if (!it0_edge)                 ie0_q <= 1'b0;
      else if (p0_fall)              ie0_q <= 1'b1;
      else if (take && grant[0])     ie0_q <= 1'b0;

      if (tmr0_ovf)                  tf0_q <= 1'b1;
      else if (take && grant[1])     tf0_q <= 1'b0;

      if (p1_edge)                   ie1_q <= 1'b1;
      else if (take && grant[2])     ie1_q <= 1'b0;

      if (tmr1_ovf)                  tf1_q <= 1'b1;
      else if (take && grant[3])     tf1_q <= 1'b0;

      if (take)                      svc_q <= 1'b1;
      else if (reti)                 svc_q <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_ctl_single_level_chk.sv
module irq_ctl_single_level_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_wr,
  input logic [7:0]       en_rdata,
  input logic             irq_ack,
  input logic             reti,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic             svc_q
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (en_rdata == 8'h00 && !irq_req));

  p_bit4_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> !en_rdata[4]);

  p_global_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> en_rdata[7]);

  p_idle_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_vec == '0);

  p_vec_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec == VEC_W'(8'h03) || irq_vec == VEC_W'(8'h0B) ||
                 irq_vec == VEC_W'(8'h13) || irq_vec == VEC_W'(8'h1B) ||
                 irq_vec == VEC_W'(8'h2B) || irq_vec == VEC_W'(8'h53)));

  p_ack_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !irq_req);

  p_svc_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_q && !reti) |=> !irq_req);

endmodule

bind irq_ctl_single_level irq_ctl_single_level_chk #(.VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_wr    (en_wr),
  .en_rdata (en_rdata),
  .irq_ack  (irq_ack),
  .reti     (reti),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec),
  .svc_q    (svc_q)
);

// File: tb/irq_ctl_single_level_test.sv
module irq_ctl_single_level_test;
  localparam int VEC_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext0_pin = 1'b1, ext1_pin = 1'b1, it0_edge = 1'b0;
  logic tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, i2c_byte_req = 1'b0, i2c_bit_req = 1'b0;
  logic en_wr = 1'b0, irq_ack = 1'b0, reti = 1'b0;
  logic [7:0] en_wdata = 8'h00;
  logic [7:0] en_rdata;
  logic irq_req;
  logic [VEC_W-1:0] irq_vec;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  irq_ctl_single_level #(.VEC_W(VEC_W)) uut (
    .clk(clk), .rst_n(rst_n), .ext0_pin(ext0_pin), .ext1_pin(ext1_pin),
    .it0_edge(it0_edge), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
    .i2c_byte_req(i2c_byte_req), .i2c_bit_req(i2c_bit_req),
    .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
    .irq_ack(irq_ack), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec));

  always #5 clk = ~clk;

  // fields: en[19:12] ext0[11] byte[10] bit[9] exp_req[8] exp_vec[7:0]
  localparam logic [19:0] TBL [8] = '{
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
    {8'h7F, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
    {8'hFF, 1'b0, 1'b1, 1'b1, 1'b1, 8'h03},
    {8'hFE, 1'b0, 1'b1, 1'b1, 1'b1, 8'h2B},
    {8'hC0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h53},
    {8'hA0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h2B},
    {8'h81, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
    {8'h90, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00}
  };

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_en(input logic [7:0] v);
    en_wr = 1'b1; en_wdata = v;
    step();
    en_wr = 1'b0;
  endtask

  task automatic ack_then_reti();
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    reti = 1'b1; step(); reti = 1'b0;
  endtask

  task automatic pulse_t0();
    tmr0_ovf = 1'b1; step(); tmr0_ovf = 1'b0;
  endtask

  task automatic pulse_t1();
    tmr1_ovf = 1'b1; step(); tmr1_ovf = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    check("R1 req in reset", irq_req, 0);
    check("R1 vec in reset", irq_vec, 0);
    check("R1 en in reset", en_rdata, 0);
    rst_n = 1'b1;
    step();
    check("R1 req after reset", irq_req, 0);

    // R2 R3 R4 table of enable/level patterns, INT0 in level mode
    for (int r = 0; r < 8; r++) begin
      ext0_pin = TBL[r][11];
      i2c_byte_req = TBL[r][10];
      i2c_bit_req = TBL[r][9];
      wr_en(TBL[r][19:12]);
      step(2);
      check("R2 en readback", en_rdata, TBL[r][19:12] & 8'hEF);
      check("R3 req", irq_req, TBL[r][8]);
      check("R4 vec", irq_vec, TBL[r][7:0]);
    end
    ext0_pin = 1'b1; i2c_byte_req = 1'b0; i2c_bit_req = 1'b0;
    step(3);

    // R7 R8 timer 0 served, flag cleared by ack
    wr_en(8'h82);
    pulse_t0();
    check("R7 t0 req", irq_req, 1);
    check("R4 t0 vec", irq_vec, 8'h0B);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    check("R8 req after ack", irq_req, 0);
    step();
    check("R8 req held", irq_req, 0);
    reti = 1'b1; step(); reti = 1'b0;
    check("R7 t0 flag cleared", irq_req, 0);

    // R4 R8 R9 ordering and no preemption
    wr_en(8'h8A);
    tmr0_ovf = 1'b1; tmr1_ovf = 1'b1; step(); tmr0_ovf = 1'b0; tmr1_ovf = 1'b0;
    check("R4 t0 before t1", irq_vec, 8'h0B);
    ack_then_reti();
    check("R9 t1 after reti", irq_vec, 8'h1B);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    pulse_t0();
    check("R8 no preempt", irq_req, 0);
    reti = 1'b1; step(); reti = 1'b0;
    check("R9 pending t0 offered", irq_vec, 8'h0B);
    ack_then_reti();
    check("R7 all cleared", irq_req, 0);

    // R5 pin 1 both edges
    wr_en(8'h84);
    ext1_pin = 1'b0;
    step(2);
    check("R5 not yet after 2", irq_req, 0);
    step();
    check("R5 fall req", irq_req, 1);
    check("R5 fall vec", irq_vec, 8'h13);
    ack_then_reti();
    check("R5 cleared", irq_req, 0);
    ext1_pin = 1'b1;
    step(3);
    check("R5 rise vec", irq_vec, 8'h13);
    ack_then_reti();
    check("R5 cleared rise", irq_req, 0);

    // R6 pin 0 edge vs level
    wr_en(8'h81);
    it0_edge = 1'b1;
    ext0_pin = 1'b0;
    step(3);
    check("R6 edge vec", irq_vec, 8'h03);
    ack_then_reti();
    check("R6 edge held low no req", irq_req, 0);
    it0_edge = 1'b0;
    #1;
    check("R6 level req", irq_vec, 8'h03);
    ext0_pin = 1'b1;
    step(2);
    check("R6 level released", irq_req, 0);

    // R7 I2C level held by source
    wr_en(8'hA0);
    i2c_byte_req = 1'b1;
    #1;
    check("R7 i2c vec", irq_vec, 8'h2B);
    ack_then_reti();
    check("R7 i2c still held", irq_vec, 8'h2B);
    i2c_byte_req = 1'b0;
    #1;
    check("R7 i2c dropped", irq_req, 0);

    // R1 reset mid-operation
    wr_en(8'hFF);
    pulse_t1();
    check("R1 pre-reset req", irq_vec, 8'h1B);
    rst_n = 1'b0;
    step();
    check("R1 en cleared", en_rdata, 0);
    check("R1 req cleared", irq_req, 0);
    rst_n = 1'b1;
    step();
    wr_en(8'hFF);
    check("R1 flags cleared", irq_req, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule